// File: doc/BRIEF.md
# Prescaled Modulo Timer with Compare Channel

This block is a free-running up-counter that sits behind a simple 32-bit register bus with separate read and write strobes, an address and a data word. The counter is built either 16 or 32 bits wide, and software can read that width back. The counter steps on counter-clock ticks that have passed a power-of-two prescaler. When the count reaches a programmable top value, the next step returns it to zero and latches an overflow flag.

One compare channel watches the count. In software-compare mode, the channel latches a match flag on the step that brings the count to the channel value. Both flags are cleared by writing one to them, and they share their registers with control fields. Each flag drives the single interrupt output while its enable bit is set.

The counter-clock tick arrives as a single-cycle enable that is synchronous to the bus clock. Any crossing between clock domains is done outside the block.

Top module: `cmp_timer`

## Requirements
- R1: A read of offset 0x04 returns the counter width in bits in bits 23:16: 0x10 for a 16-bit build and 0x20 for a 32-bit build. All other bits read zero.
- R2: After reset, the registers hold these values and `irq` is low:
  - control (0x10) reads 0;
  - count (0x14) reads 0;
  - top (0x18) reads all ones for the built width;
  - channel control (0x20) reads 0;
  - channel value (0x24) reads 0.
- R3: While control bit 3 is 1, the count steps once every 2^k asserted `cnt_tick` cycles, where k is control bits 2:0. While bit 3 is 0, the count holds.
- R4: A step taken while the count equals the top value (0x18) returns the count to 0 and sets the overflow flag, which reads in control bit 7.
- R5: Writing control with bit 7 = 1 clears the overflow flag. Writing it with bit 7 = 0 leaves the flag unchanged. Bits 6 and 3:0 of the write are stored.
- R6: Any write to the count offset clears the count to 0 and restarts the prescaler, whatever the write data is.
- R7: When channel control bits 5:2 equal 1 (software compare), the step that makes the count equal the channel value (0x24) sets the channel flag in channel control bit 7. With any other mode value the flag is never set.
- R8: Writing channel control with bit 7 = 1 clears the channel flag. Writing it with bit 7 = 0 leaves the flag unchanged. Bits 6:2 of the write are stored.
- R9: `irq` is high exactly when (overflow flag AND control bit 6) OR (channel flag AND channel control bit 6).
- R10: In a 16-bit build, bits 31:16 of the count, top and channel value registers read as zero and are not stored on writes.
- R11: Offset 0x1C is read-only and mirrors the channel flag in bit 0 and the overflow flag in bit 8.
- R12: Read data appears on `bus_rdata` in the cycle after a cycle with `bus_rd` high. Unmapped offsets read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and counter logic clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cnt_tick | input | 1 | Counter-clock tick enable, synchronous to clk |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with a 16-bit counter. This setting makes the masking of the upper register bits observable. It also keeps a full-range wrap of the counter, from 0 through 0xFFFF and back to 0, within a short run.

Against that build, the bench sweeps all eight prescaler settings, several small top values and channel values at 0, at 1 and at the top. From the number of enabled cycles it computes the expected final count, the overflow flag and whether a compare hit occurred.

// File: rtl/cmp_timer_pkg.sv
package cmp_timer_pkg;
  localparam int unsigned BUS_W  = 32;
  localparam int unsigned ADDR_W = 8;
  localparam int unsigned DIV_W  = 3;

  localparam logic [ADDR_W-1:0] OFF_WIDTH = 8'h04;
  localparam logic [ADDR_W-1:0] OFF_CTRL  = 8'h10;
  localparam logic [ADDR_W-1:0] OFF_COUNT = 8'h14;
  localparam logic [ADDR_W-1:0] OFF_TOP   = 8'h18;
  localparam logic [ADDR_W-1:0] OFF_FLAGS = 8'h1C;
  localparam logic [ADDR_W-1:0] OFF_CHCTL = 8'h20;
  localparam logic [ADDR_W-1:0] OFF_CHVAL = 8'h24;

  localparam int unsigned CTRL_RUN_BIT  = 3;
  localparam int unsigned CTRL_IE_BIT   = 6;
  localparam int unsigned CTRL_FLAG_BIT = 7;
  localparam int unsigned CH_MODE_LSB   = 2;
  localparam int unsigned CH_IE_BIT     = 6;
  localparam int unsigned CH_FLAG_BIT   = 7;
  localparam int unsigned FLAGS_CH_BIT  = 0;
  localparam int unsigned FLAGS_OV_BIT  = 8;

  localparam logic [3:0] MODE_SW_CMP = 4'd1;

  typedef struct packed {
    logic             ie;
    logic             run;
    logic [DIV_W-1:0] div;
  } ctrl_t;

  typedef struct packed {
    logic       ie;
    logic [3:0] mode;
  } chctl_t;
endpackage

// File: rtl/cmp_timer_prescale.sv
module cmp_timer_prescale #(
  parameter int unsigned DIV_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic             restart,
  input  logic [DIV_W-1:0] div,
  output logic             step
);
  localparam int unsigned PW = (1 << DIV_W) - 1;

  logic [PW-1:0] acc_q, acc_d, mask;
  logic          adv;

  always_comb begin
    for (int i = 0; i < PW; i++) begin
      mask[i] = (i < int'(div));
    end
  end

  assign adv  = run & tick;
  assign step = adv & ((acc_q & mask) == mask);

  always_comb begin
    acc_d = acc_q;
    if (restart) begin
      acc_d = '0;
    end else if (adv) begin
      acc_d = step ? '0 : acc_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
    end else begin
      acc_q <= acc_d;
    end
  end
endmodule

// File: rtl/cmp_timer_counter.sv
module cmp_timer_counter #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  input  logic         clear,
  input  logic [W-1:0] top,
  output logic [W-1:0] count,
  output logic [W-1:0] nxt,
  output logic         wrap
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         at_top;

  assign at_top = (cnt_q == top);
  assign nxt    = at_top ? '0 : cnt_q + 1'b1;
  assign wrap   = step & ~clear & at_top;

  always_comb begin
    cnt_d = cnt_q;
    if (clear) begin
      cnt_d = '0;
    end else if (step) begin
      cnt_d = nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign count = cnt_q;
endmodule

// File: rtl/cmp_timer_channel.sv
module cmp_timer_channel #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  input  logic [W-1:0] nxt,
  input  logic [W-1:0] match_val,
  input  logic [3:0]   mode,
  input  logic         flag_clr,
  output logic         flag
);
  import cmp_timer_pkg::*;

  logic flag_q, flag_d, hit;

  assign hit = step & (mode == MODE_SW_CMP) & (nxt == match_val);

  always_comb begin
    flag_d = flag_q;
    if (flag_clr) begin
      flag_d = 1'b0;
    end
    if (hit) begin
      flag_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else begin
      flag_q <= flag_d;
    end
  end

  assign flag = flag_q;
endmodule

// File: rtl/cmp_timer.sv
module cmp_timer #(
  parameter int unsigned CNT_W = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cnt_tick,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [7:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        irq
);
  import cmp_timer_pkg::*;

  localparam logic [7:0] WIDTH_CODE = 8'(CNT_W);

  ctrl_t            ctrl_q, ctrl_d;
  chctl_t           chctl_q, chctl_d;
  logic [CNT_W-1:0] top_q, top_d;
  logic [CNT_W-1:0] chval_q, chval_d;
  logic             tof_q, tof_d;
  logic [31:0]      rdata_q, rdata_d;

  logic             wr_ctrl, wr_count, wr_top, wr_chctl, wr_chval;
  logic             step_raw, step_eff, cnt_clr, wrap;
  logic [CNT_W-1:0] cnt_q, cnt_nxt;
  logic             chf_q;
  logic             run_q;
  logic [3:0]       chmode_q;

  assign wr_ctrl  = bus_wr & (bus_addr == OFF_CTRL);
  assign wr_count = bus_wr & (bus_addr == OFF_COUNT);
  assign wr_top   = bus_wr & (bus_addr == OFF_TOP);
  assign wr_chctl = bus_wr & (bus_addr == OFF_CHCTL);
  assign wr_chval = bus_wr & (bus_addr == OFF_CHVAL);

  assign cnt_clr  = wr_count;
  assign step_eff = step_raw & ~cnt_clr;
  assign run_q    = ctrl_q.run;
  assign chmode_q = chctl_q.mode;

  cmp_timer_prescale #(.DIV_W(DIV_W)) u_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (ctrl_q.run),
    .tick    (cnt_tick),
    .restart (cnt_clr),
    .div     (ctrl_q.div),
    .step    (step_raw)
  );

  cmp_timer_counter #(.W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .step  (step_eff),
    .clear (cnt_clr),
    .top   (top_q),
    .count (cnt_q),
    .nxt   (cnt_nxt),
    .wrap  (wrap)
  );

  cmp_timer_channel #(.W(CNT_W)) u_ch0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .step      (step_eff),
    .nxt       (cnt_nxt),
    .match_val (chval_q),
    .mode      (chctl_q.mode),
    .flag_clr  (wr_chctl & bus_wdata[CH_FLAG_BIT]),
    .flag      (chf_q)
  );

  always_comb begin
    ctrl_d  = ctrl_q;
    chctl_d = chctl_q;
    top_d   = top_q;
    chval_d = chval_q;
    tof_d   = tof_q;
    if (wr_ctrl) begin
      ctrl_d.ie  = bus_wdata[CTRL_IE_BIT];
      ctrl_d.run = bus_wdata[CTRL_RUN_BIT];
      ctrl_d.div = bus_wdata[DIV_W-1:0];
      if (bus_wdata[CTRL_FLAG_BIT]) begin
        tof_d = 1'b0;
      end
    end
    if (wrap) begin
      tof_d = 1'b1;
    end
    if (wr_chctl) begin
      chctl_d.ie   = bus_wdata[CH_IE_BIT];
      chctl_d.mode = bus_wdata[CH_MODE_LSB +: 4];
    end
    if (wr_top) begin
      top_d = bus_wdata[CNT_W-1:0];
    end
    if (wr_chval) begin
      chval_d = bus_wdata[CNT_W-1:0];
    end
  end

  always_comb begin
    rdata_d = '0;
    case (bus_addr)
      OFF_WIDTH: rdata_d[23:16] = WIDTH_CODE;
      OFF_CTRL: begin
        rdata_d[CTRL_FLAG_BIT] = tof_q;
        rdata_d[CTRL_IE_BIT]   = ctrl_q.ie;
        rdata_d[CTRL_RUN_BIT]  = ctrl_q.run;
        rdata_d[DIV_W-1:0]     = ctrl_q.div;
      end
      OFF_COUNT: rdata_d[CNT_W-1:0] = cnt_q;
      OFF_TOP:   rdata_d[CNT_W-1:0] = top_q;
      OFF_FLAGS: begin
        rdata_d[FLAGS_CH_BIT] = chf_q;
        rdata_d[FLAGS_OV_BIT] = tof_q;
      end
      OFF_CHCTL: begin
        rdata_d[CH_FLAG_BIT]          = chf_q;
        rdata_d[CH_IE_BIT]            = chctl_q.ie;
        rdata_d[CH_MODE_LSB +: 4]     = chctl_q.mode;
      end
      OFF_CHVAL: rdata_d[CNT_W-1:0] = chval_q;
      default:   rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      chctl_q <= '0;
      top_q   <= '1;
      chval_q <= '0;
      tof_q   <= 1'b0;
    end else begin
      ctrl_q  <= ctrl_d;
      chctl_q <= chctl_d;
      top_q   <= top_d;
      chval_q <= chval_d;
      tof_q   <= tof_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (bus_rd) begin
      rdata_q <= rdata_d;
    end
  end

  assign bus_rdata = rdata_q;
  assign irq       = (tof_q & ctrl_q.ie) | (chf_q & chctl_q.ie);
endmodule

// File: rtl/cmp_timer_chk.sv
module cmp_timer_chk #(
  parameter int unsigned W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         run,
  input logic         cnt_clr,
  input logic [W-1:0] count,
  input logic [W-1:0] top,
  input logic         tof,
  input logic         chf,
  input logic [W-1:0] chval,
  input logic [3:0]   chmode
);
  a_r4_wrap_sets_ovf: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tof) |-> (count == '0) && ($past(count) == $past(top)));

  a_r7_hit_at_match: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(chf) |-> (count == chval) && (chmode == 4'd1));

  a_r3_hold_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(run) && !$past(cnt_clr)) |-> $stable(count));

  a_r6_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_clr |=> (count == '0));

  a_r3_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    (count != $past(count)) |-> (count == '0) || (count == $past(count) + 1'b1));
endmodule

bind cmp_timer cmp_timer_chk #(.W(CNT_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .run     (run_q),
  .cnt_clr (cnt_clr),
  .count   (cnt_q),
  .top     (top_q),
  .tof     (tof_q),
  .chf     (chf_q),
  .chval   (chval_q),
  .chmode  (chmode_q)
);

// File: tb/cmp_timer_test.sv
module cmp_timer_test;
  localparam int W = 16;

  logic        clk;
  logic        rst_n;
  logic        cnt_tick;
  logic        bus_wr;
  logic        bus_rd;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        irq;

  int tests;
  int fails;
  int cyc;
  bit done;

  cmp_timer #(.CNT_W(W)) uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .cnt_tick  (cnt_tick),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq       (irq)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 195000 && !done) begin
      done = 1'b1;
      fails++;
      tests++;
      $display("FAIL watchdog: actual cycles %0d expected < 195000", cyc);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
    bus_rd = 1'b0;
  endtask

  function automatic bit hit_expected(int steps, int m, int v, int mode);
    bit h = 0;
    if (mode != 1) return 0;
    for (int k = 1; k <= steps; k++) begin
      if ((k % (m + 1)) == v) h = 1;
    end
    return h;
  endfunction

  // Run p/m/v/mode for n idle cycles, then stop and compare.
  task automatic run_case(input int p, input int m, input int v, input int mode, input int n);
    logic [31:0] r, r2;
    int e, steps, ecnt;
    bit etof, echf;
    wr(8'h10, 32'h0000_0080);
    wr(8'h20, 32'h0000_0080);
    wr(8'h20, 32'h40 | (mode << 2));
    wr(8'h24, v);
    wr(8'h18, m);
    wr(8'h14, 32'h0000_BEEF);
    wr(8'h10, 32'h48 | p);
    repeat (n) @(negedge clk);
    wr(8'h10, 32'h40 | p);
    e     = n + 1;
    steps = e >> p;
    ecnt  = steps % (m + 1);
    etof  = (steps >= m + 1);
    echf  = hit_expected(steps, m, v, mode);
    rd(8'h14, r);
    check("R3 count after prescaled run", r, ecnt);
    repeat (5) @(negedge clk);
    rd(8'h14, r2);
    check("R3 count holds while stopped", r2, ecnt);
    rd(8'h10, r);
    check("R4 overflow flag and R5 stored ctrl", r, (32'(etof) << 7) | 32'h40 | p);
    rd(8'h20, r);
    check("R7 channel flag", r, (32'(echf) << 7) | 32'h40 | (mode << 2));
    rd(8'h1C, r);
    check("R11 flag mirror", r, (32'(etof) << 8) | 32'(echf));
    check("R9 irq", irq, etof | echf);
  endtask

  initial begin
    logic [31:0] r;
    tests = 0; fails = 0; cyc = 0; done = 0;
    rst_n = 1'b0; cnt_tick = 1'b1;
    bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    check("R2 irq after reset", irq, 1'b0);
    rd(8'h10, r); check("R2 ctrl reset", r, 32'h0);
    rd(8'h14, r); check("R2 count reset", r, 32'h0);
    rd(8'h18, r); check("R2 top reset", r, 32'h0000_FFFF);
    rd(8'h20, r); check("R2 channel ctrl reset", r, 32'h0);
    rd(8'h24, r); check("R2 channel value reset", r, 32'h0);
    rd(8'h04, r); check("R1 width readout", r, 32'h0010_0000);
    rd(8'h08, r); check("R12 unmapped read", r, 32'h0);

    wr(8'h18, 32'hABCD_1234);
    rd(8'h18, r); check("R10 top upper bits", r, 32'h0000_1234);
    wr(8'h24, 32'hFFFF_0007);
    rd(8'h24, r); check("R10 channel value upper bits", r, 32'h0000_0007);

    for (int p = 0; p < 8; p++) begin
      for (int mi = 0; mi < 3; mi++) begin
        int m;
        m = (mi == 0) ? 1 : (mi == 1) ? 2 : 5;
        run_case(p, m, 0, 1, (m + 2) * (1 << p) + p);
        run_case(p, m, 1, 1, (1 << p) * 2 - 1);
        run_case(p, m, m, 1, (m + 1) * (1 << p) + 3);
        run_case(p, m, 1, 2, (m + 2) * (1 << p));
      end
    end

    // Full 16-bit range: wraps once, ends at a small count.
    run_case(0, 32'hFFFF, 5, 1, 65536 + 9);

    // R6: count write with nonzero data clears.
    wr(8'h10, 32'h0000_0008);
    repeat (20) @(negedge clk);
    wr(8'h14, 32'hFFFF_FFFF);
    wr(8'h10, 32'h0000_0000);
    rd(8'h14, r); check("R6 count write clears", r, 32'h1);

    // R5/R8/R9: clear flags one at a time through their registers.
    run_case(0, 3, 2, 1, 10);
    wr(8'h10, 32'h0000_0040);
    rd(8'h10, r); check("R5 write 0 keeps overflow flag", r, 32'h0000_00C0);
    wr(8'h20, 32'h0000_0084);
    rd(8'h20, r); check("R8 channel flag cleared", r, 32'h0000_0004);
    check("R9 irq from overflow only", irq, 1'b1);
    wr(8'h10, 32'h0000_0000);
    check("R9 irq masked by enable", irq, 1'b0);
    rd(8'h10, r); check("R5 flag kept when masked", r, 32'h0000_0080);
    wr(8'h10, 32'h0000_0080);
    rd(8'h1C, r); check("R5 overflow flag cleared", r, 32'h0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule